// File: doc/BRIEF.md
# Integer ALU with Status Flags

This block is the integer execution unit of a small 32-bit RISC core. It is purely combinational. Each cycle it receives an operation code and two source operands from decode, together with the core's current carry bit and compare flag. It returns the value to write back, a write-enable for the register file, the next carry and compare-flag values, and an exception strobe for an illegal division. Register file, decode and pipeline sequencing sit outside it.

The unit covers addition with and without carry-in, subtraction, bitwise logic, three shifts, a move of a half-width immediate into the upper half, sign and zero extension of bytes and halfwords, a flag-driven conditional select, a find-first-one scan and ten set-flag comparisons. Multiply and the two divides are built in by default, using plain operators, and can be removed with a parameter. Carry is derived from an unsigned "result below first addend" test. A configuration input lets add, add-with-carry and AND also write a zero indication into the compare flag.

Top module: `int_alu`

## Requirements
- R1: ADD (op 0) gives result = (src_a + src_b) mod 2^32, and ADDC (op 1) adds one more when carry_i is 1. Both assert wr_en_o.
- R2: For ADD and ADDC, carry_o is 1 exactly when the unsigned result is below src_a. A case such as src_a=5, src_b=0xFFFFFFFF, carry_i=1 therefore gives result 5 and carry_o 0. Every other op code passes carry_i to carry_o unchanged.
- R3: SUB (op 2) gives src_a - src_b mod 2^32, with write enabled and the carry unchanged.
- R4: When arith_flag_en_i is 1, ADD, ADDC and AND (op 3) drive flag_o to 1 if their result is zero and to 0 otherwise. When it is 0, and for every non-compare op, flag_o equals flag_i.
- R5: AND (op 3), OR (op 4) and XOR (op 5) give the bitwise result with write enabled.
- R6: SLL (op 6), SRL (op 7) and SRA (op 8) shift src_a by the low 5 bits of src_b. SRL fills with zeros and SRA fills with src_a bit 31.
- R7: MOVHI (op 9) gives {src_b[15:0], 16'h0000}.
- R8: The extension ops all read only src_a[7:0] or src_a[15:0]. EXTBS (op 10) sign-extends the low byte, EXTBZ (op 11) zero-extends it, EXTHS (op 12) sign-extends the low halfword and EXTHZ (op 13) zero-extends it.
- R9: CMOV (op 14) gives src_a when flag_i is 1 and src_b when it is 0.
- R10: FF1 (op 15) gives the 1-based position of the lowest set bit of src_a, or 0 when src_a is zero.
- R11: The compare ops set flag_o to the outcome and drive wr_en_o 0 and result_o 0. They are EQ (19), NE (20), unsigned GT/GE/LT/LE (21-24) and signed GT/GE/LT/LE (25-28).
- R12: MUL (op 16) gives the low 32 bits of the product. DIV (op 17, signed) and DIVU (op 18, unsigned) give the quotient truncated toward zero. With src_b zero, either divide asserts illegal_o, drives wr_en_o 0 and result_o 0. illegal_o is 0 for every other case.
- R13: Op codes 29 to 31 drive result_o 0, wr_en_o 0 and illegal_o 0, and pass both flags through.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| op_i | input | 5 | Operation code |
| src_a_i | input | 32 | First source operand |
| src_b_i | input | 32 | Second source operand; also carries the immediate for MOVHI |
| carry_i | input | 1 | Current carry bit |
| flag_i | input | 1 | Current compare flag |
| arith_flag_en_i | input | 1 | Lets ADD, ADDC and AND write a zero indication to the flag |
| result_o | output | 32 | Write-back value |
| wr_en_o | output | 1 | Result is to be written |
| carry_o | output | 1 | Next carry bit |
| flag_o | output | 1 | Next compare flag |
| illegal_o | output | 1 | Division by zero exception strobe |

## Verification
All five outputs are combinational, so each one is due in the same cycle as the operands that produce it. No result has any latency to track. The bench applies every vector on a falling edge. At the following rising edge it compares all outputs against a behavioural model fed the same inputs, so the outputs have half a period to settle and are never sampled while an input is changing. Directed vectors cover the carry quirk, the zero flag under both settings, shift amounts above 31, extreme operands for signed and unsigned compares and division by zero. Several thousand random vectors over all 32 op codes follow.

// File: rtl/alu_pkg.sv
package alu_pkg;

   localparam int OP_W = 5;

   typedef enum logic [OP_W-1:0] {
      OP_ADD   = 5'd0,
      OP_ADDC  = 5'd1,
      OP_SUB   = 5'd2,
      OP_AND   = 5'd3,
      OP_OR    = 5'd4,
      OP_XOR   = 5'd5,
      OP_SLL   = 5'd6,
      OP_SRL   = 5'd7,
      OP_SRA   = 5'd8,
      OP_MOVHI = 5'd9,
      OP_EXTBS = 5'd10,
      OP_EXTBZ = 5'd11,
      OP_EXTHS = 5'd12,
      OP_EXTHZ = 5'd13,
      OP_CMOV  = 5'd14,
      OP_FF1   = 5'd15,
      OP_MUL   = 5'd16,
      OP_DIV   = 5'd17,
      OP_DIVU  = 5'd18,
      OP_SFEQ  = 5'd19,
      OP_SFNE  = 5'd20,
      OP_SFGTU = 5'd21,
      OP_SFGEU = 5'd22,
      OP_SFLTU = 5'd23,
      OP_SFLEU = 5'd24,
      OP_SFGTS = 5'd25,
      OP_SFGES = 5'd26,
      OP_SFLTS = 5'd27,
      OP_SFLES = 5'd28
   } alu_op_e;

   typedef enum logic [1:0] {
      SH_LEFT  = 2'd0,
      SH_RLOG  = 2'd1,
      SH_RARI  = 2'd2
   } shift_kind_e;

endpackage

// File: rtl/alu_addsub.sv
module alu_addsub #(
   parameter int WIDTH = 32
) (
   input  logic [WIDTH-1:0] a_i,
   input  logic [WIDTH-1:0] b_i,
   input  logic             sub_i,
   input  logic             cin_i,
   output logic [WIDTH-1:0] sum_o,
   output logic             below_o
);
   logic [WIDTH-1:0] b_eff;
   logic [WIDTH-1:0] cin_vec;

   // Subtraction reuses the adder as a + ~b + 1.
   assign b_eff   = sub_i ? ~b_i : b_i;
   assign cin_vec = {{(WIDTH-1){1'b0}}, (sub_i | cin_i)};
   assign sum_o   = a_i + b_eff + cin_vec;
   // Carry is defined by comparing the sum against the first addend.
   assign below_o = (sum_o < a_i);
endmodule

// File: rtl/alu_shifter.sv
module alu_shifter
   import alu_pkg::*;
#(
   parameter int WIDTH        = 32,
   parameter bit STAGED_SHIFT = 1,
   localparam int SHW         = $clog2(WIDTH)
) (
   input  logic [WIDTH-1:0] a_i,
   input  logic [SHW-1:0]   amt_i,
   input  shift_kind_e      kind_i,
   output logic [WIDTH-1:0] y_o
);
   logic fill;
   logic [WIDTH-1:0] left_y;
   logic [WIDTH-1:0] right_y;

   assign fill = (kind_i == SH_RARI) & a_i[WIDTH-1];

   generate
      if (STAGED_SHIFT) begin : g_staged
         logic [WIDTH-1:0] ls [SHW+1];
         logic [WIDTH-1:0] rs [SHW+1];
         assign ls[0] = a_i;
         assign rs[0] = a_i;
         for (genvar k = 0; k < SHW; k++) begin : g_stage
            localparam int P = 2 ** k;
            assign ls[k+1] = amt_i[k] ? {ls[k][WIDTH-1-P:0], {P{1'b0}}} : ls[k];
            assign rs[k+1] = amt_i[k] ? {{P{fill}}, rs[k][WIDTH-1:P]}   : rs[k];
         end
         assign left_y  = ls[SHW];
         assign right_y = rs[SHW];
      end else begin : g_operator
         logic [WIDTH-1:0] fill_mask;
         assign fill_mask = ~({WIDTH{1'b1}} >> amt_i);
         assign left_y    = a_i << amt_i;
         assign right_y   = (a_i >> amt_i) | ({WIDTH{fill}} & fill_mask);
      end
   endgenerate

   assign y_o = (kind_i == SH_LEFT) ? left_y : right_y;
endmodule

// File: rtl/alu_ff1.sv
module alu_ff1 #(
   parameter int WIDTH = 32,
   localparam int IDXW = $clog2(WIDTH + 1)
) (
   input  logic [WIDTH-1:0] a_i,
   output logic [IDXW-1:0]  idx_o
);
   // Scan from the top so the lowest set bit is the last one to win.
   always_comb begin
      idx_o = '0;
      for (int i = WIDTH - 1; i >= 0; i--) begin
         if (a_i[i]) idx_o = IDXW'(i + 1);
      end
   end
endmodule

// File: rtl/alu_compare.sv
module alu_compare
   import alu_pkg::*;
#(
   parameter int WIDTH = 32
) (
   input  alu_op_e          op_i,
   input  logic [WIDTH-1:0] a_i,
   input  logic [WIDTH-1:0] b_i,
   output logic             is_cmp_o,
   output logic             flag_o
);
   logic eq, ltu, lts;

   assign eq  = (a_i == b_i);
   assign ltu = (a_i < b_i);
   assign lts = ($signed(a_i) < $signed(b_i));

   always_comb begin
      is_cmp_o = 1'b1;
      flag_o   = 1'b0;
      case (op_i)
         OP_SFEQ:  flag_o = eq;
         OP_SFNE:  flag_o = ~eq;
         OP_SFGTU: flag_o = ~ltu & ~eq;
         OP_SFGEU: flag_o = ~ltu;
         OP_SFLTU: flag_o = ltu;
         OP_SFLEU: flag_o = ltu | eq;
         OP_SFGTS: flag_o = ~lts & ~eq;
         OP_SFGES: flag_o = ~lts;
         OP_SFLTS: flag_o = lts;
         OP_SFLES: flag_o = lts | eq;
         default:  is_cmp_o = 1'b0;
      endcase
   end
endmodule

// File: rtl/int_alu.sv
module int_alu
   import alu_pkg::*;
#(
   parameter int WIDTH        = 32,
   parameter int IMM_W        = 16,
   parameter bit HAS_MULDIV   = 1,
   parameter bit STAGED_SHIFT = 1
) (
   input  logic [OP_W-1:0]  op_i,
   input  logic [WIDTH-1:0] src_a_i,
   input  logic [WIDTH-1:0] src_b_i,
   input  logic             carry_i,
   input  logic             flag_i,
   input  logic             arith_flag_en_i,
   output logic [WIDTH-1:0] result_o,
   output logic             wr_en_o,
   output logic             carry_o,
   output logic             flag_o,
   output logic             illegal_o
);
   localparam int SHW  = $clog2(WIDTH);
   localparam int IDXW = $clog2(WIDTH + 1);
   localparam int BYTE = 8;
   localparam int HALF = 16;

   generate
      if (WIDTH < 2 * HALF || (WIDTH & (WIDTH - 1)) != 0) begin : g_bad_width
         $error("int_alu: WIDTH must be a power of two of at least 32");
      end
      if (IMM_W * 2 != WIDTH) begin : g_bad_imm
         $error("int_alu: IMM_W must be half of WIDTH");
      end
   endgenerate

   alu_op_e op;
   assign op = alu_op_e'(op_i);

   // Adder / subtractor
   logic [WIDTH-1:0] sum;
   logic             sum_below;

   alu_addsub #(.WIDTH(WIDTH)) u_addsub (
      .a_i     (src_a_i),
      .b_i     (src_b_i),
      .sub_i   (op == OP_SUB),
      .cin_i   ((op == OP_ADDC) & carry_i),
      .sum_o   (sum),
      .below_o (sum_below)
   );

   // Shifter
   shift_kind_e      sh_kind;
   logic [WIDTH-1:0] sh_y;

   always_comb begin
      case (op)
         OP_SRL:  sh_kind = SH_RLOG;
         OP_SRA:  sh_kind = SH_RARI;
         default: sh_kind = SH_LEFT;
      endcase
   end

   alu_shifter #(.WIDTH(WIDTH), .STAGED_SHIFT(STAGED_SHIFT)) u_shift (
      .a_i    (src_a_i),
      .amt_i  (src_b_i[SHW-1:0]),
      .kind_i (sh_kind),
      .y_o    (sh_y)
   );

   // Find first one
   logic [IDXW-1:0] ff1_idx;

   alu_ff1 #(.WIDTH(WIDTH)) u_ff1 (
      .a_i   (src_a_i),
      .idx_o (ff1_idx)
   );

   // Set-flag comparisons
   logic is_cmp, cmp_flag;

   alu_compare #(.WIDTH(WIDTH)) u_cmp (
      .op_i     (op),
      .a_i      (src_a_i),
      .b_i      (src_b_i),
      .is_cmp_o (is_cmp),
      .flag_o   (cmp_flag)
   );

   // Optional multiply / divide
   logic [WIDTH-1:0] mul_y, divs_y, divu_y;
   logic             div_zero;

   assign div_zero = (src_b_i == '0);

   generate
      if (HAS_MULDIV) begin : g_muldiv
         assign mul_y  = src_a_i * src_b_i;
         assign divs_y = div_zero ? '0 : WIDTH'($signed(src_a_i) / $signed(src_b_i));
         assign divu_y = div_zero ? '0 : (src_a_i / src_b_i);
      end else begin : g_no_muldiv
         assign mul_y  = '0;
         assign divs_y = '0;
         assign divu_y = '0;
      end
   endgenerate

   // Result selection and flag updates
   logic [WIDTH-1:0] res;
   logic             we, cy, fl, ill;
   logic             zero_upd;

   always_comb begin
      res      = '0;
      we       = 1'b0;
      cy       = carry_i;
      ill      = 1'b0;
      zero_upd = 1'b0;
      case (op)
         OP_ADD, OP_ADDC: begin
            res      = sum;
            we       = 1'b1;
            cy       = sum_below;
            zero_upd = 1'b1;
         end
         OP_SUB: begin
            res = sum;
            we  = 1'b1;
         end
         OP_AND: begin
            res      = src_a_i & src_b_i;
            we       = 1'b1;
            zero_upd = 1'b1;
         end
         OP_OR: begin
            res = src_a_i | src_b_i;
            we  = 1'b1;
         end
         OP_XOR: begin
            res = src_a_i ^ src_b_i;
            we  = 1'b1;
         end
         OP_SLL, OP_SRL, OP_SRA: begin
            res = sh_y;
            we  = 1'b1;
         end
         OP_MOVHI: begin
            res = {src_b_i[IMM_W-1:0], {(WIDTH-IMM_W){1'b0}}};
            we  = 1'b1;
         end
         OP_EXTBS: begin
            res = {{(WIDTH-BYTE){src_a_i[BYTE-1]}}, src_a_i[BYTE-1:0]};
            we  = 1'b1;
         end
         OP_EXTBZ: begin
            res = {{(WIDTH-BYTE){1'b0}}, src_a_i[BYTE-1:0]};
            we  = 1'b1;
         end
         OP_EXTHS: begin
            res = {{(WIDTH-HALF){src_a_i[HALF-1]}}, src_a_i[HALF-1:0]};
            we  = 1'b1;
         end
         OP_EXTHZ: begin
            res = {{(WIDTH-HALF){1'b0}}, src_a_i[HALF-1:0]};
            we  = 1'b1;
         end
         OP_CMOV: begin
            res = flag_i ? src_a_i : src_b_i;
            we  = 1'b1;
         end
         OP_FF1: begin
            res = {{(WIDTH-IDXW){1'b0}}, ff1_idx};
            we  = 1'b1;
         end
         OP_MUL: begin
            if (HAS_MULDIV) begin
               res = mul_y;
               we  = 1'b1;
            end
         end
         OP_DIV, OP_DIVU: begin
            if (HAS_MULDIV) begin
               if (div_zero) begin
                  ill = 1'b1;
               end else begin
                  res = (op == OP_DIV) ? divs_y : divu_y;
                  we  = 1'b1;
               end
            end
         end
         default: begin
         end
      endcase
   end

   always_comb begin
      if (is_cmp)
         fl = cmp_flag;
      else if (zero_upd && arith_flag_en_i)
         fl = (res == '0);
      else
         fl = flag_i;
   end

   assign result_o  = res;
   assign wr_en_o   = we;
   assign carry_o   = cy;
   assign flag_o    = fl;
   assign illegal_o = ill;
endmodule

// File: rtl/int_alu_chk.sv
module int_alu_chk #(
   parameter int WIDTH = 32
) (
   input logic [4:0]       op_i,
   input logic [WIDTH-1:0] src_a_i,
   input logic [WIDTH-1:0] src_b_i,
   input logic             carry_i,
   input logic             flag_i,
   input logic             arith_flag_en_i,
   input logic [WIDTH-1:0] result_o,
   input logic             wr_en_o,
   input logic             carry_o,
   input logic             flag_o,
   input logic             illegal_o
);
   always_comb begin
      // R12: a zero divisor excepts and suppresses the write
      if ((op_i == 5'd17 || op_i == 5'd18) && src_b_i == '0) begin
         a_r12_div_zero: assert (illegal_o && !wr_en_o && result_o == '0)
            else $error("R12 divide by zero not flagged");
      end
      // R12: only divides may raise the exception
      if (illegal_o) begin
         a_r12_only_div: assert (op_i == 5'd17 || op_i == 5'd18)
            else $error("R12 exception from non-divide op");
      end
      // R11: compares never write and keep the carry
      if (op_i >= 5'd19 && op_i <= 5'd28) begin
         a_r11_cmp_nowrite: assert (!wr_en_o && result_o == '0 && carry_o == carry_i)
            else $error("R11 compare wrote a result");
      end
      // R4: or/xor/shift leave the flag alone whatever the option
      if (op_i >= 5'd4 && op_i <= 5'd8) begin
         a_r4_flag_hold: assert (flag_o == flag_i && carry_o == carry_i)
            else $error("R4 flag or carry changed by logic/shift op");
      end
      // R7: the low half after a high-immediate move is zero
      if (op_i == 5'd9) begin
         a_r7_movhi_low: assert (result_o[WIDTH/2-1:0] == '0 && wr_en_o)
            else $error("R7 low half not cleared");
      end
      // R10: index range and zero case
      if (op_i == 5'd15) begin
         a_r10_ff1_range: assert (result_o <= WIDTH && ((result_o == '0) == (src_a_i == '0)))
            else $error("R10 index out of range");
      end
      // R13: undefined codes are inert
      if (op_i >= 5'd29) begin
         a_r13_inert: assert (!wr_en_o && !illegal_o && flag_o == flag_i && carry_o == carry_i)
            else $error("R13 undefined op had an effect");
      end
      // R4: without the option, add/addc/and keep the flag
      if (!arith_flag_en_i && op_i <= 5'd3) begin
         a_r4_no_zero_upd: assert (flag_o == flag_i)
            else $error("R4 flag changed while option off");
      end
   end
endmodule

bind int_alu int_alu_chk #(.WIDTH(WIDTH)) u_int_alu_chk (
   .op_i            (op_i),
   .src_a_i         (src_a_i),
   .src_b_i         (src_b_i),
   .carry_i         (carry_i),
   .flag_i          (flag_i),
   .arith_flag_en_i (arith_flag_en_i),
   .result_o        (result_o),
   .wr_en_o         (wr_en_o),
   .carry_o         (carry_o),
   .flag_o          (flag_o),
   .illegal_o       (illegal_o)
);

// File: tb/int_alu_bench.sv
module int_alu_bench;
   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic [4:0]  op = '0;
   logic [31:0] a = '0, b = '0;
   logic        cin = 1'b0, fin = 1'b0, fen = 1'b0;
   logic [31:0] result;
   logic        wr_en, carry, flag, illegal;

   int total = 0;
   int bad   = 0;
   bit done  = 1'b0;

   always #2 clk = ~clk;   // 250 MHz

   int_alu u_int_alu (
      .op_i            (op),
      .src_a_i         (a),
      .src_b_i         (b),
      .carry_i         (cin),
      .flag_i          (fin),
      .arith_flag_en_i (fen),
      .result_o        (result),
      .wr_en_o         (wr_en),
      .carry_o         (carry),
      .flag_o          (flag),
      .illegal_o       (illegal)
   );

   function automatic string tag_of(input logic [4:0] o);
      if (o <= 5'd1)  return "R1/R2/R4";
      if (o == 5'd2)  return "R3";
      if (o <= 5'd5)  return "R5/R4";
      if (o <= 5'd8)  return "R6";
      if (o == 5'd9)  return "R7";
      if (o <= 5'd13) return "R8";
      if (o == 5'd14) return "R9";
      if (o == 5'd15) return "R10";
      if (o <= 5'd18) return "R12";
      if (o <= 5'd28) return "R11";
      return "R13";
   endfunction

   // Behavioural reference for one vector
   task automatic model(
      input  logic [4:0]  o,
      input  logic [31:0] x, y,
      input  logic        c, f, en,
      output logic [31:0] r,
      output logic        w, cy, fl, il);
      longint unsigned wide;
      r = 0; w = 0; cy = c; fl = f; il = 0;
      case (o)
         5'd0, 5'd1: begin
            wide = longint'(x) + longint'(y) + ((o == 5'd1 && c) ? 1 : 0);
            r = wide[31:0]; w = 1;
            cy = (r < x) ? 1'b1 : 1'b0;
            if (en) fl = (r == 0);
         end
         5'd2:  begin r = x - y; w = 1; end
         5'd3:  begin r = x & y; w = 1; if (en) fl = (r == 0); end
         5'd4:  begin r = x | y; w = 1; end
         5'd5:  begin r = x ^ y; w = 1; end
         5'd6:  begin r = x << (y % 32); w = 1; end
         5'd7:  begin r = x >> (y % 32); w = 1; end
         5'd8:  begin r = $signed(x) >>> (y % 32); w = 1; end
         5'd9:  begin r = (y % 65536) * 65536; w = 1; end
         5'd10: begin r = (x[7] ? 32'hFFFFFF00 : 0) | (x % 256); w = 1; end
         5'd11: begin r = x % 256; w = 1; end
         5'd12: begin r = (x[15] ? 32'hFFFF0000 : 0) | (x % 65536); w = 1; end
         5'd13: begin r = x % 65536; w = 1; end
         5'd14: begin r = f ? x : y; w = 1; end
         5'd15: begin
            w = 1;
            for (int i = 0; i < 32; i++) begin
               if (x[i]) begin r = i + 1; break; end
            end
         end
         5'd16: begin wide = longint'(x) * longint'(y); r = wide[31:0]; w = 1; end
         5'd17: begin
            if (y == 0) il = 1;
            else begin r = $signed(x) / $signed(y); w = 1; end
         end
         5'd18: begin
            if (y == 0) il = 1;
            else begin r = x / y; w = 1; end
         end
         5'd19: fl = (x == y);
         5'd20: fl = (x != y);
         5'd21: fl = (x > y);
         5'd22: fl = (x >= y);
         5'd23: fl = (x < y);
         5'd24: fl = (x <= y);
         5'd25: fl = ($signed(x) >  $signed(y));
         5'd26: fl = ($signed(x) >= $signed(y));
         5'd27: fl = ($signed(x) <  $signed(y));
         5'd28: fl = ($signed(x) <= $signed(y));
         default: ;
      endcase
   endtask

   // Drive on the falling edge, compare at the next rising edge
   task automatic run(input logic [4:0] o, input logic [31:0] x, y,
                      input logic c, f, en, input string tag);
      logic [31:0] er; logic ew, ec, ef, ei;
      @(negedge clk);
      op = o; a = x; b = y; cin = c; fin = f; fen = en;
      @(posedge clk);
      model(o, x, y, c, f, en, er, ew, ec, ef, ei);
      total++;
      if (result !== er || wr_en !== ew || carry !== ec || flag !== ef || illegal !== ei) begin
         bad++;
         $display("FAIL %s op=%0d a=%h b=%h: got res=%h we=%b cy=%b fl=%b ill=%b exp res=%h we=%b cy=%b fl=%b ill=%b",
                  tag, o, x, y, result, wr_en, carry, flag, illegal, er, ew, ec, ef, ei);
      end
   endtask

   function automatic logic [31:0] pick();
      case ($urandom_range(0, 5))
         0: return 32'h0;
         1: return 32'hFFFFFFFF;
         2: return 32'h80000000;
         3: return $urandom_range(0, 9);
         default: return $urandom;
      endcase
   endfunction

   initial begin
      repeat (3) @(posedge clk);
      rst = 1'b0;
      // Idle state: all-zero inputs are an ADD of zeros
      run(5'd0, 0, 0, 0, 0, 0, "R1 idle");
      // R1 / R2 / R4 corners
      run(5'd0, 32'hFFFFFFFF, 32'h1, 0, 0, 1, "R2 wrap sets carry, R4 zero flag");
      run(5'd0, 32'h10, 32'h20, 1, 1, 1, "R1 add ignores carry, R4 flag clears");
      run(5'd1, 32'h1, 32'h2, 1, 0, 0, "R1 addc adds carry");
      run(5'd1, 32'h5, 32'hFFFFFFFF, 1, 0, 0, "R2 addc equal-result quirk");
      run(5'd1, 32'hFFFFFFFF, 32'h0, 1, 0, 1, "R2 addc wrap, R4 zero");
      run(5'd3, 32'hF0, 32'h0F, 0, 0, 1, "R4 and zero with option");
      run(5'd3, 32'hF0, 32'h0F, 0, 0, 0, "R4 and zero without option");
      run(5'd4, 32'h0, 32'h0, 1, 0, 1, "R4 or keeps flag");
      run(5'd2, 32'h0, 32'h1, 1, 1, 1, "R3 sub borrow keeps carry");
      run(5'd5, 32'hA5A5A5A5, 32'hFFFF0000, 0, 0, 0, "R5 xor");
      // R6 shifts with amount above 31
      run(5'd8, 32'h80000000, 32'd63, 0, 0, 0, "R6 sra fill");
      run(5'd7, 32'h80000000, 32'd63, 0, 0, 0, "R6 srl fill");
      run(5'd6, 32'h00000003, 32'd33, 0, 0, 0, "R6 sll low bits");
      run(5'd9, 32'h0, 32'h1234ABCD, 0, 0, 0, "R7 movhi");
      run(5'd10, 32'h12345680, 0, 0, 0, 0, "R8 extbs");
      run(5'd13, 32'hFFFF8000, 0, 0, 0, 0, "R8 exthz");
      run(5'd12, 32'h00008001, 0, 0, 0, 0, "R8 exths");
      run(5'd14, 32'h11111111, 32'h22222222, 0, 1, 0, "R9 cmov flag set");
      run(5'd14, 32'h11111111, 32'h22222222, 0, 0, 0, "R9 cmov flag clear");
      run(5'd15, 32'h0, 0, 0, 0, 0, "R10 ff1 zero");
      run(5'd15, 32'h80000000, 0, 0, 0, 0, "R10 ff1 top bit");
      run(5'd15, 32'h00000C00, 0, 0, 0, 0, "R10 ff1 mid");
      run(5'd25, 32'h80000000, 32'h1, 0, 1, 0, "R11 signed gt");
      run(5'd21, 32'h80000000, 32'h1, 0, 0, 0, "R11 unsigned gt");
      run(5'd24, 32'h7, 32'h7, 1, 0, 0, "R11 unsigned le equal");
      run(5'd17, 32'h7, 32'h0, 0, 0, 0, "R12 div by zero");
      run(5'd18, 32'h7, 32'h0, 1, 1, 0, "R12 divu by zero");
      run(5'd17, 32'hFFFFFFF9, 32'h2, 0, 0, 0, "R12 signed div truncates");
      run(5'd18, 32'h7, 32'h2, 0, 0, 0, "R12 divu");
      run(5'd16, 32'hFFFFFFFF, 32'h3, 0, 0, 0, "R12 mul low bits");
      run(5'd30, 32'h5, 32'h6, 1, 1, 1, "R13 undefined code");
      // Random sweep across all op codes
      for (int n = 0; n < 4000; n++) begin
         logic [4:0] o;
         o = 5'($urandom_range(0, 31));
         run(o, pick(), pick(), 1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)),
             1'($urandom_range(0, 1)), tag_of(o));
      end
      done = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         bad++;
         $display("FAIL watchdog expired");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end
endmodule